// File: doc/BRIEF.md
# Dual-Clock Serial Field Delay Memory

This block is a sequential-access nibble store with one serial input port and one serial output port, each clocked by its own clock. The two clocks may be unrelated and may run at different rates. Words enter at a write pointer that steps by one on each qualified write clock edge. Words leave at a read pointer that steps in the same way on the read clock. Neither pointer is compared with the other, and there is no full or empty flag. The delay from input to output is set only by when each side's pointer is returned to address zero. A video pipeline uses this to hold back one field by a chosen number of read clocks.

Each port has two controls. The enable freezes the port's pointer. The pass control lets the pointer keep moving but suppresses the data transfer. On the write side, dropping pass leaves selected locations untouched, so a region can be overwritten while the rest of the field is kept. On the read side, dropping pass skips words, and the output shows zero with its valid flag low. Either clock may be stopped at any level without disturbing the stored words. The depth is 2^ADDR_W words, and ADDR_W may be set as high as 18.

Top module: `fdm_field_delay`

## Requirements
- R1: On a write clock rising edge with wr_en=1 and wr_pass=1, wr_data is stored at the write pointer, and the pointer then advances by one.
- R2: On a write clock edge with wr_en=0 and wr_zero=0, nothing is stored and the write pointer keeps its value.
- R3: On a write clock edge with wr_en=1 and wr_pass=0, the write pointer advances by one and the addressed location keeps its old contents.
- R4: On a read clock rising edge with rd_en=1 and rd_pass=1, rd_data takes the word at the read pointer and rd_valid goes to 1 from that edge on, and the read pointer then advances by one.
- R5: On a read clock edge with rd_en=0, the read pointer, rd_data and rd_valid all keep their values.
- R6: On a read clock edge with rd_en=1 and rd_pass=0, the read pointer advances by one, so that word is skipped. From that edge on, rd_data reads 4'h0 and rd_valid reads 0.
- R7: wr_zero=1 on a write clock edge sets the address used at that edge to zero, and it does so ahead of wr_en. If wr_en=1, that edge acts on address 0 and the pointer leaves at 1. If wr_en=0, the pointer leaves at 0 and nothing is stored.
- R8: rd_zero=1 on a read clock edge sets the address used at that edge to zero, and it does so ahead of rd_en. If rd_en=1, the word at address 0 appears on that same edge with no extra latency, and the pointer leaves at 1. If rd_en=0, the outputs hold and the pointer leaves at 0.
- R9: A pointer at address 2^ADDR_W-1 that advances wraps to address 0.
- R10: While rst_n is low and after it is released, rd_valid is 0 and rd_data is 4'h0, and both pointers start at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write port clock |
| rclk | input | 1 | Read port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_zero | input | 1 | Returns the write pointer to address 0 (R7) |
| wr_en | input | 1 | Write enable; when low, the write pointer is frozen |
| wr_pass | input | 1 | Write pass; when low, the store is suppressed but the pointer still moves |
| wr_data | input | 4 | Nibble to store |
| rd_zero | input | 1 | Returns the read pointer to address 0 (R8) |
| rd_en | input | 1 | Read enable; when low, the read pointer and the outputs are frozen |
| rd_pass | input | 1 | Read pass; when low, the word is skipped and the output is blanked |
| rd_data | output | 4 | Nibble read out; 4'h0 while rd_valid is low |
| rd_valid | output | 1 | High when rd_data carries a transferred word |

## Verification
A pointer return to zero and a port's enable or pass control can fall on the same clock edge. The return to zero must win the choice of address, while the enable still decides whether that edge moves the pointer and whether it transfers data. The bench provokes this by raising wr_zero together with wr_en, and also with wr_en low. It does the same on the read side with rd_zero and rd_en. Each outcome is judged at the ports: the read-back contents and the first word delivered must match what a model built only from the requirements predicts for address 0.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  // What a port does with its current address on a clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,  // pointer frozen, no transfer
    ACT_MOVE = 2'd1,  // pointer steps, transfer suppressed
    ACT_XFER = 2'd2   // pointer steps and data moves
  } port_act_e;
endpackage

// File: rtl/fdm_rst_sync.sv
module fdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = chain_q[LAST];
endmodule

// File: rtl/fdm_ptr.sv
module fdm_ptr
  import fdm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero,
  input  logic              en,
  input  logic              pass,
  output logic [ADDR_W-1:0] addr_now,
  output port_act_e         act
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_ce;

  // Action decode: the enable gates motion, pass gates the transfer.
  always_comb begin
    if (!en)       act = ACT_HOLD;
    else if (pass) act = ACT_XFER;
    else           act = ACT_MOVE;
  end

  // A zero request overrides the stored pointer for this edge.
  always_comb begin
    addr_now = zero ? '0 : ptr_q;
    ptr_d    = (act == ACT_HOLD) ? addr_now : addr_now + ADDR_W'(1);
    ptr_ce   = zero | en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_ce) ptr_q <= ptr_d;
  end

  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !en && !zero) |=> $stable(ptr_q));

  a_r1_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && en && !zero) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

  a_r7_zero_active: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && zero && en) |=> (ptr_q == ADDR_W'(1)));

  a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && zero && !en) |=> (ptr_q == '0));
endmodule

// File: rtl/fdm_store.sv
module fdm_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/fdm_field_delay.sv
module fdm_field_delay
  import fdm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wr_zero,
  input  logic              wr_en,
  input  logic              wr_pass,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_zero,
  input  logic              rd_en,
  input  logic              rd_pass,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              wrst_n, rrst_n;
  logic [ADDR_W-1:0] waddr, raddr;
  port_act_e         wact, ract;
  logic [DATA_W-1:0] word_q;
  logic              valid_q, valid_d, valid_ce;

  fdm_rst_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk(wclk), .arst_n(rst_n), .rst_n_o(wrst_n));
  fdm_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(rclk), .arst_n(rst_n), .rst_n_o(rrst_n));

  fdm_ptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk(wclk), .rst_n(wrst_n), .zero(wr_zero), .en(wr_en),
    .pass(wr_pass), .addr_now(waddr), .act(wact));

  fdm_ptr #(.ADDR_W(ADDR_W)) u_rptr (
    .clk(rclk), .rst_n(rrst_n), .zero(rd_zero), .en(rd_en),
    .pass(rd_pass), .addr_now(raddr), .act(ract));

  fdm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .wclk(wclk), .we(wact == ACT_XFER), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .re(ract == ACT_XFER), .raddr(raddr), .rdata(word_q));

  // Valid flag: updated whenever the read pointer moves.
  always_comb begin
    valid_ce = (ract != ACT_HOLD);
    valid_d  = (ract == ACT_XFER);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)        valid_q <= 1'b0;
    else if (valid_ce)  valid_q <= valid_d;
  end

  assign rd_valid = valid_q;
  assign rd_data  = valid_q ? word_q : '0;

  a_r6_skip_blank: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rrst_n && rd_en && !rd_pass) |=> (!rd_valid && rd_data == '0));

  a_r5_out_hold: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rrst_n && !rd_en) |=> ($stable(rd_valid) && $stable(rd_data)));

  a_r4_xfer_valid: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rrst_n && rd_en && rd_pass) |=> rd_valid);

  a_r10_quiet_reset: assert property (@(posedge rclk)
    (!rrst_n) |-> (!rd_valid && rd_data == '0));
endmodule

// File: tb/fdm_field_delay_test.sv
module fdm_field_delay_test;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic       wr_zero = 1'b0, wr_en = 1'b0, wr_pass = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic       rd_zero = 1'b0, rd_en = 1'b0, rd_pass = 1'b0;
  logic [3:0] rd_data;
  logic       rd_valid;

  int n_chk = 0, n_bad = 0;
  logic [3:0] mdl [DEPTH];
  int         wp = 0, rp = 0;
  logic [3:0] e_data = 4'h0;
  logic       e_valid = 1'b0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  fdm_field_delay #(.ADDR_W(AW)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_zero(wr_zero), .wr_en(wr_en), .wr_pass(wr_pass), .wr_data(wr_data),
    .rd_zero(rd_zero), .rd_en(rd_en), .rd_pass(rd_pass),
    .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic z, input logic e, input logic p, input logic [3:0] d);
    int a;
    @(negedge wclk);
    wr_zero = z; wr_en = e; wr_pass = p; wr_data = d;
    @(posedge wclk);
    #1 wr_zero = 1'b0; wr_en = 1'b0;
    a = z ? 0 : wp;
    if (e && p) mdl[a] = d;
    wp = e ? (a + 1) % DEPTH : a;
  endtask

  task automatic rd(input logic z, input logic e, input logic p, input string tag);
    int a;
    @(negedge rclk);
    rd_zero = z; rd_en = e; rd_pass = p;
    @(posedge rclk);
    #1 rd_zero = 1'b0; rd_en = 1'b0;
    a = z ? 0 : rp;
    if (e) begin
      e_valid = p;
      e_data  = p ? mdl[a] : 4'h0;
      rp = (a + 1) % DEPTH;
    end else begin
      rp = a;
    end
    @(negedge rclk);
    check({tag, " data"}, rd_data, e_data);
    check({tag, " valid"}, {3'b0, rd_valid}, {3'b0, e_valid});
  endtask

  // R10: outputs quiet and pointers at zero after reset; R1/R4 plain streaming.
  task automatic t_reset_fill;
    check("R10 data at reset", rd_data, 4'h0);
    check("R10 valid at reset", {3'b0, rd_valid}, 4'h0);
    for (int i = 0; i < DEPTH; i++) wr(1'b0, 1'b1, 1'b1, 4'((i * 7 + 3) & 15));
    for (int i = 0; i < 4; i++) rd(1'b0, 1'b1, 1'b1, "R10 R4 first reads");
  endtask

  // R8 and R4: word 0 appears on the reset edge itself, then steps on.
  task automatic t_stream;
    rd(1'b1, 1'b1, 1'b1, "R8 first word");
    for (int i = 0; i < 9; i++) rd(1'b0, 1'b1, 1'b1, "R4 stream");
  endtask

  // R2: stalled write edges neither store nor move.
  task automatic t_wr_hold;
    wr(1'b1, 1'b1, 1'b1, 4'h1);
    wr(1'b0, 1'b1, 1'b1, 4'h2);
    wr(1'b0, 1'b0, 1'b1, 4'hE);
    wr(1'b0, 1'b0, 1'b0, 4'hD);
    wr(1'b0, 1'b0, 1'b1, 4'hC);
    wr(1'b0, 1'b1, 1'b1, 4'h3);
    rd(1'b1, 1'b1, 1'b1, "R2 hold a0");
    rd(1'b0, 1'b1, 1'b1, "R2 hold a1");
    rd(1'b0, 1'b1, 1'b1, "R2 hold a2");
    rd(1'b0, 1'b1, 1'b1, "R2 hold a3");
  endtask

  // R3: masked writes step the pointer but keep old contents.
  task automatic t_wr_mask;
    for (int i = 0; i < 8; i++) wr(i == 0, 1'b1, 1'b1, 4'h6);
    for (int i = 0; i < 8; i++) wr(i == 0, 1'b1, (i % 2) == 0, 4'(8 + i));
    rd(1'b1, 1'b1, 1'b1, "R3 mask");
    for (int i = 1; i < 8; i++) rd(1'b0, 1'b1, 1'b1, "R3 mask");
  endtask

  // R5: frozen read edges keep pointer and outputs.
  task automatic t_rd_hold;
    rd(1'b1, 1'b1, 1'b1, "R5 pre");
    rd(1'b0, 1'b1, 1'b1, "R5 pre");
    for (int i = 0; i < 3; i++) rd(1'b0, 1'b0, i == 1, "R5 frozen");
    rd(1'b0, 1'b1, 1'b1, "R5 resume");
    rd(1'b0, 1'b1, 1'b1, "R5 resume");
  endtask

  // R6: skipped words blank the output and still consume addresses.
  task automatic t_skip;
    rd(1'b1, 1'b1, 1'b1, "R6 pre");
    rd(1'b0, 1'b1, 1'b0, "R6 skip");
    rd(1'b0, 1'b1, 1'b0, "R6 skip");
    rd(1'b0, 1'b0, 1'b1, "R6 hold after skip");
    rd(1'b0, 1'b1, 1'b1, "R6 after skip");
  endtask

  // R7/R8: zero requests win over the enables on the same edge.
  task automatic t_prio;
    wr(1'b0, 1'b1, 1'b1, 4'h4);
    wr(1'b1, 1'b0, 1'b1, 4'hF);
    wr(1'b0, 1'b1, 1'b1, 4'h9);
    wr(1'b1, 1'b1, 1'b0, 4'h7);
    wr(1'b0, 1'b1, 1'b1, 4'hA);
    rd(1'b0, 1'b1, 1'b1, "R8 pre");
    rd(1'b1, 1'b0, 1'b1, "R8 zero idle");
    rd(1'b0, 1'b1, 1'b1, "R7 R8 addr0");
    rd(1'b0, 1'b1, 1'b1, "R7 addr1");
  endtask

  // R9: both pointers wrap past the last address.
  task automatic t_wrap;
    for (int i = 0; i < DEPTH + 3; i++) wr(i == 0, 1'b1, 1'b1, 4'((i * 5 + 1) & 15));
    rd(1'b1, 1'b1, 1'b1, "R9 wrap");
    for (int i = 1; i < DEPTH + 4; i++) rd(1'b0, 1'b1, 1'b1, "R9 wrap");
  endtask

  initial begin
    repeat (5) @(posedge wclk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge rclk);
    repeat (4) @(posedge wclk);
    t_reset_fill();
    t_stream();
    t_wr_hold();
    t_wr_mask();
    t_rd_hold();
    t_skip();
    t_prio();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule